// File: doc/BRIEF.md
# Ultrasonic Echo Ranging Controller

This block runs a trigger/echo ultrasonic range sensor from a fast system clock. A prescaler derives a one-microsecond tick. On that tick a fixed repetition period elapses, and at the end of each period the block raises a trigger pulse of a programmable number of microseconds. It then waits for the sensor's echo line to rise. It times how long the echo stays high, counting whole microseconds from the synchronised echo edge. That round-trip time is converted in fixed point into whole centimetres.

Each finished measurement becomes one result on a valid/ready output. A result carries a distance and a no-target flag. No-target is reported in two cases: the echo stays high up to the maximum echo width, or no echo rise arrives within a timeout after the trigger. A result is held, unchanged, until the consumer takes it by asserting ready while valid is high. The block never stalls its own measurement cycle for back-pressure. A result that has not been taken when the next one completes is replaced by the newer one. Valid may be asserted without waiting for ready.

Top module: `sonar_ranger`

## Requirements
- R1: The trigger output is high for exactly TRIG_US × CLK_PER_US consecutive clock cycles per measurement.
- R2: When the echo line is low at every period boundary, consecutive trigger rising edges are exactly PERIOD_US × CLK_PER_US clock cycles apart.
- R3: If the synchronised echo is high at a period boundary, no trigger is started in that period, and the next trigger comes one full period later.
- R4: An echo that is high for H clock cycles, with H < MAX_ECHO_US × CLK_PER_US, produces one result with the no-target flag at 0 and a round-trip time of floor(H / CLK_PER_US) µs.
- R5: The distance field of a target result equals (t × SCALE_NUM + SCALE_DEN / 2) / SCALE_DEN in integer division, where t is the measured time in µs (17 and 1000 by default, which gives centimetres).
- R6: An echo held high for MAX_ECHO_US × CLK_PER_US cycles produces a result with the no-target flag at 1 and distance 0. This result is issued without waiting for the echo to fall, and no second result follows when the echo does fall.
- R7: If no echo rise occurs within RISE_TIMEOUT_US µs after the trigger ends, a result with the no-target flag at 1 and distance 0 is issued.
- R8: While res_valid_o is high and res_ready_i is low, the valid line and the payload stay unchanged, unless a newer result completes and replaces them. A cycle with both high retires the result, so valid is low in the following cycle.
- R9: While rst_n is low, trig_o and res_valid_o are 0.
- R10: Echo pulses that arrive while no measurement is pending (between a finished result and the next trigger) produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_PER_US cycles per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| echo_i | input | 1 | Echo line from the sensor (asynchronous) |
| trig_o | output | 1 | Trigger line to the sensor |
| res_valid_o | output | 1 | A result is offered |
| res_ready_i | input | 1 | Consumer takes the offered result |
| res_dist_o | output | DIST_W | Distance in whole centimetres, 0 for no target |
| res_no_target_o | output | 1 | 1 when the result is a no-target report |

## Verification
The echo width is swept across the whole range on a small configuration. Every width is offered both as an exact microsecond multiple and with up to three extra cycles, which separates correct truncation from off-by-one counting. Widths that sit on either side of a rounding step of the distance formula show whether the half-unit rounding term is right. Widths one cycle under the saturation limit and past it separate a near-maximum distance from the no-target report. An echo that never comes, an echo that spans a period boundary, and results left unaccepted test the timeout, the trigger suppression and the hold-or-replace rule of the output.

// File: rtl/sr_pkg.sv
`timescale 1ns/1ps
package sr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRE,
    ST_ARM,
    ST_MEAS,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/sr_tick_gen.sv
`timescale 1ns/1ps
module sr_tick_gen #(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(CLK_PER_US - 1));
  assign tick_o = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/sr_sync.sv
`timescale 1ns/1ps
module sr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= async_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign rise_o  = s2_q & ~prev_q;
  assign fall_o  = ~s2_q & prev_q;
endmodule

// File: rtl/sr_sequencer.sv
`timescale 1ns/1ps
module sr_sequencer import sr_pkg::*; #(
  parameter int unsigned CLK_PER_US      = 50,
  parameter int unsigned TRIG_US         = 10,
  parameter int unsigned PERIOD_US       = 60000,
  parameter int unsigned MAX_ECHO_US     = 38000,
  parameter int unsigned RISE_TIMEOUT_US = 2000,
  localparam int unsigned W_W = $clog2(MAX_ECHO_US + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           echo_i,
  input  logic           rise_i,
  input  logic           fall_i,
  output logic           trig_o,
  output logic           done_o,
  output logic [W_W-1:0] width_o,
  output logic           nt_o
);
  localparam int unsigned SUB_W  = $clog2(CLK_PER_US);
  localparam int unsigned PCNT_W = $clog2(PERIOD_US);
  localparam int unsigned TLIM   = (TRIG_US > RISE_TIMEOUT_US) ? TRIG_US : RISE_TIMEOUT_US;
  localparam int unsigned TCNT_W = $clog2(TLIM + 1);

  seq_state_e        state_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [SUB_W-1:0]  sub_q;
  logic [W_W-1:0]    width_q;
  logic              done_q, nt_q;
  logic              period_end;

  assign period_end = tick_i && (pcnt_q == PCNT_W'(PERIOD_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
      tcnt_q  <= '0;
      sub_q   <= '0;
      width_q <= '0;
      done_q  <= 1'b0;
      nt_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) pcnt_q <= period_end ? '0 : pcnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (period_end && !echo_i) begin
            state_q <= ST_FIRE;
            tcnt_q  <= '0;
          end
        end
        ST_FIRE: begin
          if (tick_i) begin
            if (tcnt_q == TCNT_W'(TRIG_US - 1)) begin
              state_q <= ST_ARM;
              tcnt_q  <= '0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        ST_ARM: begin
          if (rise_i) begin
            state_q <= ST_MEAS;
            sub_q   <= SUB_W'(1);
            width_q <= '0;
          end else if (tick_i) begin
            if (tcnt_q == TCNT_W'(RISE_TIMEOUT_US - 1)) begin
              state_q <= ST_IDLE;
              width_q <= '0;
              nt_q    <= 1'b1;
              done_q  <= 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        ST_MEAS: begin
          if (fall_i) begin
            state_q <= ST_IDLE;
            nt_q    <= 1'b0;
            done_q  <= 1'b1;
          end else if (sub_q == SUB_W'(CLK_PER_US - 1)) begin
            sub_q <= '0;
            if (width_q == W_W'(MAX_ECHO_US - 1)) begin
              width_q <= W_W'(MAX_ECHO_US);
              nt_q    <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_DRAIN;
            end else begin
              width_q <= width_q + 1'b1;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (!echo_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign trig_o  = (state_q == ST_FIRE);
  assign done_o  = done_q;
  assign width_o = width_q;
  assign nt_o    = nt_q;

  // checker-only counter of trigger high cycles
  int unsigned fire_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_len_q <= 0;
    else if (trig_o) fire_len_q <= fire_len_q + 1;
    else fire_len_q <= 0;
  end

  AST_FIRE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_o) |-> (fire_len_q == TRIG_US * CLK_PER_US)); // R1
  AST_NO_FIRE_ON_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> !$past(echo_i)); // R3
  AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    width_o <= W_W'(MAX_ECHO_US)); // R6
  AST_TARGET_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !nt_o) |-> (width_o < W_W'(MAX_ECHO_US))); // R4
endmodule

// File: rtl/sr_scaler.sv
`timescale 1ns/1ps
module sr_scaler #(
  parameter int unsigned MAX_ECHO_US = 38000,
  parameter int unsigned SCALE_NUM   = 17,
  parameter int unsigned SCALE_DEN   = 1000,
  parameter int unsigned DIST_W      = 10,
  localparam int unsigned W_W = $clog2(MAX_ECHO_US + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [W_W-1:0]    in_width_i,
  input  logic              in_nt_i,
  output logic              out_valid_o,
  output logic [DIST_W-1:0] out_dist_o,
  output logic              out_nt_o
);
  localparam int unsigned PROD_W = $clog2(MAX_ECHO_US * SCALE_NUM + SCALE_DEN / 2 + 1);

  logic [PROD_W-1:0] prod, quot;

  assign prod = PROD_W'(in_width_i) * PROD_W'(SCALE_NUM) + PROD_W'(SCALE_DEN / 2);
  assign quot = prod / PROD_W'(SCALE_DEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_dist_o  <= '0;
      out_nt_o    <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_nt_o   <= in_nt_i;
        out_dist_o <= in_nt_i ? '0 : DIST_W'(quot);
      end
    end
  end

  AST_ONE_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o); // R4
endmodule

// File: rtl/sonar_ranger.sv
`timescale 1ns/1ps
module sonar_ranger #(
  parameter int unsigned CLK_PER_US      = 50,
  parameter int unsigned TRIG_US         = 10,
  parameter int unsigned PERIOD_US       = 60000,
  parameter int unsigned MAX_ECHO_US     = 38000,
  parameter int unsigned RISE_TIMEOUT_US = 2000,
  parameter int unsigned SCALE_NUM       = 17,
  parameter int unsigned SCALE_DEN       = 1000,
  localparam int unsigned DIST_W =
    $clog2((MAX_ECHO_US * SCALE_NUM + SCALE_DEN / 2) / SCALE_DEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              echo_i,
  output logic              trig_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DIST_W-1:0] res_dist_o,
  output logic              res_no_target_o
);
  localparam int unsigned W_W = $clog2(MAX_ECHO_US + 1);

  logic              tick;
  logic              echo_s, echo_rise, echo_fall;
  logic              seq_done, seq_nt;
  logic [W_W-1:0]    seq_width;
  logic              sc_valid, sc_nt;
  logic [DIST_W-1:0] sc_dist;

  sr_tick_gen #(.CLK_PER_US(CLK_PER_US)) tick_i0 (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  sr_sync sync_i0 (
    .clk(clk), .rst_n(rst_n), .async_i(echo_i),
    .level_o(echo_s), .rise_o(echo_rise), .fall_o(echo_fall)
  );

  sr_sequencer #(
    .CLK_PER_US(CLK_PER_US), .TRIG_US(TRIG_US), .PERIOD_US(PERIOD_US),
    .MAX_ECHO_US(MAX_ECHO_US), .RISE_TIMEOUT_US(RISE_TIMEOUT_US)
  ) seq_i0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .echo_i(echo_s), .rise_i(echo_rise), .fall_i(echo_fall),
    .trig_o(trig_o), .done_o(seq_done), .width_o(seq_width), .nt_o(seq_nt)
  );

  sr_scaler #(
    .MAX_ECHO_US(MAX_ECHO_US), .SCALE_NUM(SCALE_NUM),
    .SCALE_DEN(SCALE_DEN), .DIST_W(DIST_W)
  ) scale_i0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid_i(seq_done), .in_width_i(seq_width), .in_nt_i(seq_nt),
    .out_valid_o(sc_valid), .out_dist_o(sc_dist), .out_nt_o(sc_nt)
  );

  // output holding register: newest result wins, held until taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o     <= 1'b0;
      res_dist_o      <= '0;
      res_no_target_o <= 1'b0;
    end else if (sc_valid) begin
      res_valid_o     <= 1'b1;
      res_dist_o      <= sc_dist;
      res_no_target_o <= sc_nt;
    end else if (res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end

  AST_HOLD_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i && !sc_valid) |=>
      (res_valid_o && $stable(res_dist_o) && $stable(res_no_target_o))); // R8
  AST_RETIRE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ready_i && !sc_valid) |=> !res_valid_o); // R8
  AST_NT_ZERO_DIST: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_no_target_o) |-> (res_dist_o == '0)); // R6
endmodule

// File: tb/sonar_ranger_tb_top.sv
`timescale 1ns/1ps
module sonar_ranger_tb_top;
  localparam int K     = 4;
  localparam int TRIG  = 10;
  localparam int PER   = 700;
  localparam int MAXUS = 600;
  localparam int RTO   = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic echo = 1'b0;
  logic ready = 1'b0;
  logic trig, res_valid, res_nt;
  logic [3:0] res_dist;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sonar_ranger #(
    .CLK_PER_US(K), .TRIG_US(TRIG), .PERIOD_US(PER),
    .MAX_ECHO_US(MAXUS), .RISE_TIMEOUT_US(RTO),
    .SCALE_NUM(17), .SCALE_DEN(1000)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .echo_i(echo), .trig_o(trig),
    .res_valid_o(res_valid), .res_ready_i(ready),
    .res_dist_o(res_dist), .res_no_target_o(res_nt)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_trig(output int t);
    do @(negedge clk); while (!trig);
    t = cyc;
  endtask

  task automatic trig_len_check();
    int n = 0;
    while (trig) begin
      n++;
      @(negedge clk);
    end
    chk(n == TRIG * K, "R1 trigger width", n, TRIG * K);
  endtask

  task automatic accept();
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk(res_valid == 1'b0, "R8 valid drops after accept", int'(res_valid), 0);
  endtask

  task automatic do_meas(input int us, input int extra, input bit acc, output int t_rise);
    int exp_d = (us * 17 + 500) / 1000;
    wait_trig(t_rise);
    trig_len_check();
    repeat (6) @(negedge clk);
    echo = 1'b1;
    repeat (us * K + extra) @(negedge clk);
    echo = 1'b0;
    repeat (12) @(negedge clk);
    chk(res_valid == 1'b1, "R4 result issued", int'(res_valid), 1);
    chk(res_nt == 1'b0, "R4 target flag", int'(res_nt), 0);
    chk(int'(res_dist) == exp_d, "R5 distance", int'(res_dist), exp_d);
    if (acc) accept();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t_prev, t_now, n;
    int sweep_us [12] = '{1, 2, 29, 30, 31, 88, 89, 147, 148, 300, 451, 599};

    repeat (10) @(negedge clk);
    chk(trig == 1'b0, "R9 trigger low in reset", int'(trig), 0);
    chk(res_valid == 1'b0, "R9 valid low in reset", int'(res_valid), 0);
    rst_n = 1'b1;

    do_meas(1, 0, 1'b1, t_prev);
    for (int i = 1; i < 12; i++) begin
      do_meas(sweep_us[i], sweep_us[i] % K, 1'b1, t_now);
      chk(t_now - t_prev == PER * K, "R2 trigger period", t_now - t_prev, PER * K);
      t_prev = t_now;
    end
    for (int u = 7; u < MAXUS; u += 53) begin
      do_meas(u, (u + 1) % K, 1'b1, t_now);
      chk(t_now - t_prev == PER * K, "R2 trigger period", t_now - t_prev, PER * K);
      t_prev = t_now;
    end

    // R8: result left untaken, then replaced by a newer one
    do_meas(100, 0, 1'b0, t_prev);
    repeat (200) @(negedge clk);
    chk(res_valid == 1'b1, "R8 untaken result held", int'(res_valid), 1);
    chk(int'(res_dist) == 2, "R8 payload held", int'(res_dist), 2);
    do_meas(300, 0, 1'b1, t_now);
    t_prev = t_now;

    // R6: echo past the saturation limit
    wait_trig(t_now);
    trig_len_check();
    repeat (6) @(negedge clk);
    echo = 1'b1;
    n = 0;
    while (!res_valid && n < 2600) begin
      @(negedge clk);
      n++;
    end
    chk(n >= MAXUS * K && n <= MAXUS * K + 12, "R6 no-target while echo high", n, MAXUS * K + 5);
    chk(res_nt == 1'b1, "R6 no-target flag", int'(res_nt), 1);
    chk(int'(res_dist) == 0, "R6 zero distance", int'(res_dist), 0);
    accept();
    repeat (2500 - n) @(negedge clk);
    echo = 1'b0;
    repeat (40) @(negedge clk);
    chk(res_valid == 1'b0, "R6 no result on late fall", int'(res_valid), 0);

    // R7: echo never rises
    wait_trig(t_now);
    chk(t_now - t_prev == 2 * PER * K, "R2 period across saturation", t_now - t_prev, 2 * PER * K);
    trig_len_check();
    n = 0;
    while (!res_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(n >= RTO * K - 5 && n <= RTO * K + 15, "R7 timeout latency", n, RTO * K + 3);
    chk(res_nt == 1'b1, "R7 no-target flag", int'(res_nt), 1);
    chk(int'(res_dist) == 0, "R7 zero distance", int'(res_dist), 0);
    accept();

    // R3 and R10: stray echo spanning the next period boundary
    while (cyc < t_now + PER * K - 10) @(negedge clk);
    echo = 1'b1;
    repeat (20) @(negedge clk);
    echo = 1'b0;
    repeat (60) @(negedge clk);
    chk(res_valid == 1'b0, "R10 stray echo ignored", int'(res_valid), 0);
    t_prev = t_now;
    do_meas(250, 1, 1'b1, t_now);
    chk(t_now - t_prev == 2 * PER * K, "R3 trigger skipped", t_now - t_prev, 2 * PER * K);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule